// File: doc/BRIEF.md
# Byte-Interleaved Bus Slot Transmitter

This block places one byte stream onto a shared parallel bus on which three channels take turns byte by byte. Each bus clock cycle belongs to one of three slots. A frame sync pulse fixes which cycle is slot 1, and the block drives the bus only in the slot its configuration selects. A point-to-point mode removes the interleave, and the block then drives a byte in every cycle.

The block asks its upstream source for a byte with a request strobe. The request is raised in the cycle before the block's own slot, and the byte present on the source input at that clock edge is registered. It is then driven during the slot, together with a parity bit and an output-enable. Outside its slot the block holds data and parity at zero and keeps the enable low, so other devices can share the bus.

Top module: `busSlotTx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busOe`, `busData` and `busParity` are all zero.
- R2: In bus mode (`cfgBusMode`=1), `busOe` and `srcReq` stay low until at least one `frameSync` pulse has been sampled on a rising clock edge.
- R3: The cycle after a rising edge that samples `frameSync`=1 is slot 1. Slots then follow in the order 1, 2, 3, 1, 2, 3, ...
- R4: In bus mode with `cfgSlotSel` set to 1, 2 or 3, `busOe` is high exactly in the cycles of that slot, one cycle in every three.
- R5: `cfgSlotSel`=00 in bus mode means the block never raises `srcReq` or `busOe`.
- R6: Whenever `busOe` is low, `busData` and `busParity` are zero.
- R7: In point-to-point mode (`cfgBusMode`=0), `srcReq` is high in every cycle and `busOe` is high in every cycle after the first edge. No sync pulse is needed.
- R8: `busParity` covers the 8 driven data bits. With `cfgOddParity`=1, the count of ones across data and parity is odd. With `cfgOddParity`=0, it is even.
- R9: A `frameSync` pulse that arrives mid-stream realigns the count, so the next cycle is slot 1 whatever the previous phase was.
- R10: `srcReq` is high exactly in the cycle before an owned slot. The `srcData` value sampled at the end of that cycle is the byte on `busData` during the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgBusMode | input | 1 | 1 = three-slot bus, 0 = point-to-point |
| cfgSlotSel | input | 2 | Owned slot 1..3; 00 = none |
| cfgOddParity | input | 1 | 1 = odd parity, 0 = even |
| frameSync | input | 1 | Sync pulse; the following cycle is slot 1 |
| srcData | input | 8 | Byte from upstream source |
| srcReq | output | 1 | Byte request, high in the cycle before an owned slot |
| busData | output | 8 | Bus data, zero when not driving |
| busParity | output | 1 | Parity of busData, zero when not driving |
| busOe | output | 1 | Output-enable for the shared bus |

## Verification
The slot function is tried with each of the three slot selections after one sync pulse. This separates an off-by-one phase from a correct one, because only the owned slot may show the enable. A run with no sync, and a run with selection 00, tell a block that is idle before alignment or with no slot apart from one that drives anyway. A sync that lands mid-cycle shows whether the count realigns or keeps its old phase. Data bytes 00, FF, A5 and 01 under both parity settings separate the parity sense from the data path, and point-to-point mode shows that the interleave is removed.

// File: rtl/busSlotPkg.sv
package busSlotPkg;
  typedef struct packed {
    logic load;
    logic oddPar;
  } ctrlStrobe_t;
endpackage

// File: rtl/busSlotCtrl.sv
module busSlotCtrl
  import busSlotPkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int SEL_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgBusMode,
  input  logic [SEL_W-1:0] cfgSlotSel,
  input  logic             cfgOddParity,
  input  logic             frameSync,
  output ctrlStrobe_t      strobe,
  output logic             srcReq
);
  localparam logic [SEL_W-1:0] FIRST_SLOT = SEL_W'(1);
  localparam logic [SEL_W-1:0] LAST_SLOT  = SEL_W'(NUM_SLOTS);

  logic [SEL_W-1:0] slotIdx, nextSlot;
  logic synced, nextSynced, ownNext;

  always_comb begin
    nextSynced = synced | frameSync;
    if (frameSync || slotIdx == LAST_SLOT || slotIdx == '0)
      nextSlot = FIRST_SLOT;
    else
      nextSlot = slotIdx + SEL_W'(1);
    if (cfgBusMode)
      ownNext = nextSynced && (cfgSlotSel != '0) && (nextSlot == cfgSlotSel);
    else
      ownNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotIdx <= '0;
      synced  <= 1'b0;
    end else begin
      slotIdx <= nextSlot;
      synced  <= nextSynced;
    end
  end

  assign strobe.load   = ownNext;
  assign strobe.oddPar = cfgOddParity;
  assign srcReq        = ownNext;

  assert_sync_marks_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> slotIdx == FIRST_SLOT);
  assert_wrap_after_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    (synced && !frameSync && slotIdx == LAST_SLOT) |=> slotIdx == FIRST_SLOT);
  assert_no_req_unsynced_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBusMode && !synced && !frameSync) |-> !srcReq);
  assert_sel_zero_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBusMode && cfgSlotSel == '0) |-> !srcReq);
  assert_p2p_always_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgBusMode |-> srcReq);
endmodule

// File: rtl/busSlotDatapath.sv
module busSlotDatapath
  import busSlotPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] busData,
  output logic              busParity,
  output logic              busOe
);
  logic dataOnes;

  always_comb begin
    dataOnes = 1'b0;
    for (int b = 0; b < DATA_W; b++) dataOnes = dataOnes ^ srcData[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busData   <= '0;
      busParity <= 1'b0;
      busOe     <= 1'b0;
    end else if (strobe.load) begin
      busData   <= srcData;
      busParity <= dataOnes ^ strobe.oddPar;
      busOe     <= 1'b1;
    end else begin
      busData   <= '0;
      busParity <= 1'b0;
      busOe     <= 1'b0;
    end
  end

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> (busData == '0 && !busParity));
  assert_parity_sense_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (^{busData, busParity}) == $past(strobe.oddPar));
  assert_load_drives_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (busOe && busData == $past(srcData)));
  assert_no_load_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !busOe);
endmodule

// File: rtl/busSlotTx.sv
module busSlotTx
  import busSlotPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_SLOTS = 3,
  parameter int SEL_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgBusMode,
  input  logic [SEL_W-1:0]  cfgSlotSel,
  input  logic              cfgOddParity,
  input  logic              frameSync,
  input  logic [DATA_W-1:0] srcData,
  output logic              srcReq,
  output logic [DATA_W-1:0] busData,
  output logic              busParity,
  output logic              busOe
);
  ctrlStrobe_t strobe;

  busSlotCtrl #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgBusMode(cfgBusMode), .cfgSlotSel(cfgSlotSel),
    .cfgOddParity(cfgOddParity), .frameSync(frameSync),
    .strobe(strobe), .srcReq(srcReq));

  busSlotDatapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcData(srcData),
    .busData(busData), .busParity(busParity), .busOe(busOe));
endmodule

// File: tb/busSlotTx_tb.sv
module busSlotTx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic cfgBusMode = 1, cfgOddParity = 0, frameSync = 0;
  logic [1:0] cfgSlotSel = 0;
  logic [7:0] srcData = 0;
  logic srcReq, busParity, busOe;
  logic [7:0] busData;

  int checks = 0, fails = 0;
  bit done = 0;
  int mSlot = 0;
  bit mSynced = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busSlotTx dut_i (.clk(clk), .rstN(rstN), .cfgBusMode(cfgBusMode),
    .cfgSlotSel(cfgSlotSel), .cfgOddParity(cfgOddParity), .frameSync(frameSync),
    .srcData(srcData), .srcReq(srcReq), .busData(busData),
    .busParity(busParity), .busOe(busOe));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0; frameSync = 0; srcData = 0;
    mSlot = 0; mSynced = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 oe in reset", busOe, 0);
    chk("R1 data in reset", busData, 0);
    rstN = 1;
  endtask

  // One cycle: drive at negedge, check request, step the model, check outputs at next negedge
  task automatic step(bit sync, logic [7:0] d, output bit drove);
    int nxt;
    bit act, expPar;
    frameSync = sync; srcData = d;
    #1;
    nxt = (sync || mSlot == 3 || mSlot == 0) ? 1 : mSlot + 1;
    act = !cfgBusMode || (cfgSlotSel != 0 && (sync || mSynced) && nxt == cfgSlotSel);
    chk("R10 srcReq", srcReq, act);
    expPar = ^d ^ cfgOddParity;
    @(posedge clk); @(negedge clk);
    mSlot = nxt; mSynced = mSynced | sync;
    frameSync = 0;
    chk("R4 busOe", busOe, act);
    chk(act ? "R10 busData" : "R6 busData", busData, act ? d : 0);
    chk(act ? "R8 busParity" : "R6 busParity", busParity, act ? expPar : 0);
    drove = act;
  endtask

  task automatic testReset();
    bit dr;
    cfgBusMode = 1; cfgSlotSel = 2;
    doReset();
    chk("R1 oe first cycle", busOe, 0);
    chk("R1 parity first cycle", busParity, 0);
    step(0, 8'h3c, dr);
  endtask

  task automatic testNoSync();
    bit dr;
    int n = 0;
    cfgBusMode = 1; cfgSlotSel = 1; doReset();
    for (int i = 0; i < 8; i++) begin step(0, 8'hff, dr); n += dr; end
    chk("R2 no drive before sync", n, 0);
  endtask

  task automatic testSlot(logic [1:0] sel);
    bit dr;
    int n = 0, firstAt = -1;
    cfgBusMode = 1; cfgSlotSel = sel; doReset();
    step(1, 8'h11, dr); if (dr) firstAt = 0; n += dr;
    for (int i = 1; i < 9; i++) begin
      step(0, 8'(8'h20 + i), dr);
      if (dr && firstAt < 0) firstAt = i;
      n += dr;
    end
    chk("R4 one in three", n, 3);
    chk("R3 slot order phase", firstAt, sel - 1);
  endtask

  task automatic testSelZero();
    bit dr;
    int n = 0;
    cfgBusMode = 1; cfgSlotSel = 0; doReset();
    step(1, 8'h55, dr); n += dr;
    for (int i = 0; i < 6; i++) begin step(0, 8'h77, dr); n += dr; end
    chk("R5 sel 00 silent", n, 0);
  endtask

  task automatic testP2p();
    bit dr;
    int n = 0;
    cfgBusMode = 0; cfgSlotSel = 0; doReset();
    for (int i = 0; i < 6; i++) begin step(0, 8'(8'h80 + i), dr); n += dr; end
    chk("R7 every cycle", n, 6);
    cfgBusMode = 1;
  endtask

  task automatic testParity();
    bit dr;
    logic [7:0] pats [4] = '{8'h00, 8'hff, 8'ha5, 8'h01};
    cfgBusMode = 0; doReset();
    for (int o = 0; o < 2; o++) begin
      cfgOddParity = o[0];
      foreach (pats[k]) begin
        step(0, pats[k], dr);
        chk("R8 parity ones", $countones({busData, busParity}) % 2, o);
      end
    end
    cfgOddParity = 0; cfgBusMode = 1;
  endtask

  task automatic testResync();
    bit dr;
    cfgBusMode = 1; cfgSlotSel = 1; doReset();
    step(1, 8'h01, dr);
    step(0, 8'h02, dr);
    step(1, 8'h03, dr);
    chk("R9 resync slot 1 drives", dr, 1);
    step(0, 8'h04, dr); step(0, 8'h05, dr); step(0, 8'h06, dr);
    chk("R9 slot 1 again", dr, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testNoSync();
    testSlot(2'd1);
    testSlot(2'd2);
    testSlot(2'd3);
    testSelZero();
    testP2p();
    testParity();
    testResync();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule